// File: doc/BRIEF.md
# Video Bus Nametable Mirroring Decoder

This block sits on the memory bus of a tile-based video processor and turns each bus access into an access to one of three stores. The stores are the pattern memory, two physical 1 KB nametable pages, and a 32-byte palette. The video address space is 14 bits wide, and any wider address wraps onto it. Four logical 1 KB nametables are folded onto the two physical pages by a runtime mirroring flag. The 0x3000–0x3EFF window resolves as if it were 0x2000–0x2EFF. The palette at 0x3F00 repeats every 32 bytes up to 0x3FFF.

The nametable RAM and the palette are held inside the block. Pattern memory is outside the block. The block gives it a 13-bit address and a write enable, and takes back its read data with one cycle of latency. When a pattern ROM is present, the pattern space is read-only. When no ROM is present, the external store acts as a writable 8 KB RAM.

A read strobe returns data one cycle later on `rdata`, qualified by `rvalid`. `nt_addr` and `sel` are combinational decodes of the current address. They let the integrator see which physical location an access reaches.

Top module: `vbus_mirror_dec`

## Requirements
- R1: Only the low 14 bits of `bus_addr` are decoded. An access at A+0x4000·k behaves exactly like an access at A.
- R2: `sel` encodes the target of the current address: 0 for pattern (0x0000–0x1FFF), 1 for nametable (0x2000–0x3EFF) and 2 for palette (0x3F00–0x3FFF). The value 3 never appears.
- R3: With `mirror_sel` = 1, logical tables 0 and 1 are distinct pages, table 2 shares table 0's page and table 3 shares table 1's page. `nt_addr` = {address bit 10, address bits 9:0}.
- R4: With `mirror_sel` = 0, tables 0 and 2 are distinct pages, table 1 shares table 0's page and table 3 shares table 2's page. `nt_addr` = {address bit 11, address bits 9:0}.
- R5: An address in 0x3000–0x3EFF reaches the same nametable byte as the address 0x1000 lower, under either mirroring setting.
- R6: The palette holds 32 bytes indexed by address bits 4:0. Every address in 0x3F20–0x3FFF reaches the entry at its low five bits.
- R7: In the pattern range, `pat_addr` carries address bits 12:0. `pat_we` is high only during a `bus_wr` to the pattern range while `pat_rom_present` is 0, and the written byte lands in the external pattern RAM.
- R8: While `pat_rom_present` is 1, writes to the pattern range leave `pat_we` low, and reads return the ROM contents.
- R9: A `bus_rd` in one cycle raises `rvalid` in the next cycle, with `rdata` holding the byte of the target decoded in the read cycle. `rvalid` is 0 after a cycle without `bus_rd`, and `rdata` is 0 whenever `rvalid` is 0.
- R10: After reset, `rvalid` and `rdata` are 0 and every palette entry reads 0.
- R11: A write reaches only its decoded target. A palette write leaves the nametable byte that shares its low address bits unchanged, and a nametable write does not raise `pat_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Bus address, wrapped to 14 bits |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| mirror_sel | input | 1 | 1: pages chosen by address bit 10; 0: by address bit 11 |
| pat_rom_present | input | 1 | Pattern memory is ROM (read-only) |
| pat_rdata | input | 8 | External pattern data, valid one cycle after the address |
| pat_addr | output | 13 | External pattern memory address |
| pat_we | output | 1 | External pattern RAM write enable |
| nt_addr | output | 11 | Physical nametable address: page bit and 10-bit offset |
| sel | output | 2 | Decoded target of the current address |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | Read data valid |

## Verification
Pairs of tables are written with distinct bytes and read back through their aliases under both flag values. A swapped or wrong page bit therefore returns the other page's byte. Addresses in the 0x3000 window, in upper palette mirrors and above 0x3FFF are paired with their base addresses, which separates a correct fold from a region decode that is off by one bit. Pattern accesses are repeated with and without a ROM present, to show both the write blocking and the data source. A palette write is placed over a live nametable byte to expose any write that leaks into the wrong store.

// File: rtl/vbus_pkg.sv
`timescale 1ns/1ps
// Shared types for the video bus decoder.
package vbus_pkg;
    typedef enum logic [1:0] {
        TGT_PATTERN   = 2'd0,
        TGT_NAMETABLE = 2'd1,
        TGT_PALETTE   = 2'd2
    } vbus_tgt_e;
endpackage

// File: rtl/vbus_addr_map.sv
`timescale 1ns/1ps
// Combinational decode of a wrapped video address into a target and the
// local addresses of each store. Assumes VA_W = 14 with the palette
// in the top 256-byte block and PAGE_AW+2 <= VA_W-2.
module vbus_addr_map
    import vbus_pkg::*;
#(
    parameter int VA_W    = 14,
    parameter int PAGE_AW = 10,
    parameter int PAL_AW  = 5,
    parameter int PAT_AW  = 13
) (
    input  logic [VA_W-1:0]    va,
    input  logic               mirror_sel,
    output vbus_tgt_e          tgt,
    output logic [PAGE_AW:0]   nt_addr,
    output logic [PAL_AW-1:0]  pal_idx,
    output logic [PAT_AW-1:0]  pat_addr
);
    localparam int PAL_BLK_LSB = 8;

    // Region select: the top bit clear means pattern space; all ones in the
    // upper bits means the palette block; everything else is a nametable.
    always_comb begin
        if (!va[VA_W-1])
            tgt = TGT_PATTERN;
        else if (&va[VA_W-2:PAL_BLK_LSB])
            tgt = TGT_PALETTE;
        else
            tgt = TGT_NAMETABLE;
    end

    // Page fold: the flag picks which address bit chooses the physical page;
    // bit 12 is dropped so the 0x3000 window aliases 0x2000.
    always_comb begin
        nt_addr[PAGE_AW-1:0] = va[PAGE_AW-1:0];
        nt_addr[PAGE_AW]     = mirror_sel ? va[PAGE_AW] : va[PAGE_AW+1];
    end

    // Palette index and pattern address are the low address bits.
    always_comb begin
        pal_idx  = va[PAL_AW-1:0];
        pat_addr = va[PAT_AW-1:0];
    end
endmodule

// File: rtl/vbus_nt_ram.sv
`timescale 1ns/1ps
// Two-page nametable store: synchronous write, registered read.
// Assumes one access per cycle; a same-cycle read returns old data.
module vbus_nt_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    // Registered read port, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (re)
            q <= mem[addr];
    end
endmodule

// File: rtl/vbus_pal_ram.sv
`timescale 1ns/1ps
// Palette store in flops so that reset clears every entry; registered read.
module vbus_pal_ram #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] ent [DEPTH];

    // One flop row per entry, each cleared on reset.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[i] <= '0;
            else if (we && (idx == AW'(i)))
                ent[i] <= wdata;
        end
    end

    // Registered read of the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (re)
            q <= ent[idx];
    end
endmodule

// File: rtl/vbus_mirror_dec.sv
`timescale 1ns/1ps
// Video bus decoder top. It wraps the bus address to the video space, routes
// each access to the pattern, nametable or palette store, and returns read
// data one cycle after the strobe. Assumes the external pattern memory
// presents data one cycle after pat_addr.
module vbus_mirror_dec
    import vbus_pkg::*;
#(
    parameter int BUS_AW  = 16,
    parameter int VA_W    = 14,
    parameter int DW      = 8,
    parameter int PAGE_AW = 10,
    parameter int PAL_AW  = 5,
    parameter int PAT_AW  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              mirror_sel,
    input  logic              pat_rom_present,
    input  logic [DW-1:0]     pat_rdata,
    output logic [PAT_AW-1:0] pat_addr,
    output logic              pat_we,
    output logic [PAGE_AW:0]  nt_addr,
    output logic [1:0]        sel,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);
    localparam int NT_AW = PAGE_AW + 1;

    logic [VA_W-1:0]   va;
    vbus_tgt_e         tgt;
    vbus_tgt_e         tgt_q;
    logic [PAL_AW-1:0] pal_idx;
    logic [DW-1:0]     nt_q;
    logic [DW-1:0]     pal_q;

    // Address wrap: only the low VA_W bits take part in decoding.
    assign va = bus_addr[VA_W-1:0];

    if (BUS_AW > VA_W) begin : g_wrap
        logic unused_hi_bits;
        assign unused_hi_bits = ^bus_addr[BUS_AW-1:VA_W];
    end

    vbus_addr_map #(
        .VA_W    (VA_W),
        .PAGE_AW (PAGE_AW),
        .PAL_AW  (PAL_AW),
        .PAT_AW  (PAT_AW)
    ) u_map (
        .va         (va),
        .mirror_sel (mirror_sel),
        .tgt        (tgt),
        .nt_addr    (nt_addr),
        .pal_idx    (pal_idx),
        .pat_addr   (pat_addr)
    );

    vbus_nt_ram #(
        .AW (NT_AW),
        .DW (DW)
    ) u_nt (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && tgt == TGT_NAMETABLE),
        .re    (bus_rd && tgt == TGT_NAMETABLE),
        .addr  (nt_addr),
        .wdata (bus_wdata),
        .q     (nt_q)
    );

    vbus_pal_ram #(
        .AW (PAL_AW),
        .DW (DW)
    ) u_pal (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && tgt == TGT_PALETTE),
        .re    (bus_rd && tgt == TGT_PALETTE),
        .idx   (pal_idx),
        .wdata (bus_wdata),
        .q     (pal_q)
    );

    // Pattern write enable: only when the external store is a RAM.
    assign pat_we = bus_wr && (tgt == TGT_PATTERN) && !pat_rom_present;
    assign sel    = tgt;

    // Read tracking: remember the target of a read and flag valid data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= TGT_NAMETABLE;
            rvalid <= 1'b0;
        end else begin
            rvalid <= bus_rd;
            if (bus_rd)
                tgt_q <= tgt;
        end
    end

    // Return mux: pick the store that the read addressed, zero when idle.
    always_comb begin
        rdata = '0;
        if (rvalid) begin
            unique case (tgt_q)
                TGT_PATTERN:   rdata = pat_rdata;
                TGT_NAMETABLE: rdata = nt_q;
                TGT_PALETTE:   rdata = pal_q;
                default:       rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vbus_mirror_dec_chk.sv
`timescale 1ns/1ps
// Assertion checker for the video bus decoder, bound to the top module.
module vbus_mirror_dec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        mirror_sel,
    input logic        pat_rom_present,
    input logic        pat_we,
    input logic [10:0] nt_addr,
    input logic [1:0]  sel,
    input logic [7:0]  rdata,
    input logic        rvalid
);
    // R2
    sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'd3);

    // R3
    page_bit10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mirror_sel && sel == 2'd1) |-> (nt_addr[10] == bus_addr[10]));

    // R4
    page_bit11_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mirror_sel && sel == 2'd1) |-> (nt_addr[10] == bus_addr[11]));

    // R7
    pat_we_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_we |-> (bus_wr && sel == 2'd0));

    // R8
    rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_rom_present |-> !pat_we);

    // R9
    rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rvalid);

    // R9
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rvalid);

    // R9
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == 8'h00));
endmodule

bind vbus_mirror_dec vbus_mirror_dec_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_rd          (bus_rd),
    .bus_wr          (bus_wr),
    .mirror_sel      (mirror_sel),
    .pat_rom_present (pat_rom_present),
    .pat_we          (pat_we),
    .nt_addr         (nt_addr),
    .sel             (sel),
    .rdata           (rdata),
    .rvalid          (rvalid)
);

// File: tb/sim_vbus_mirror_dec.sv
`timescale 1ns/1ps
module sim_vbus_mirror_dec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        mirror_sel = 1'b1;
    logic        pat_rom_present = 1'b1;
    logic [7:0]  pat_rdata = '0;
    logic [12:0] pat_addr;
    logic        pat_we;
    logic [10:0] nt_addr;
    logic [1:0]  sel;
    logic [7:0]  rdata;
    logic        rvalid;

    int n_chk = 0;
    int n_bad = 0;
    logic last_we;
    logic [7:0] pram [256];

    always #5 clk = ~clk;

    vbus_mirror_dec u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mirror_sel(mirror_sel),
        .pat_rom_present(pat_rom_present), .pat_rdata(pat_rdata),
        .pat_addr(pat_addr), .pat_we(pat_we), .nt_addr(nt_addr), .sel(sel),
        .rdata(rdata), .rvalid(rvalid)
    );

    // External pattern store model: ROM returns address^0x5A, RAM stores bytes.
    always @(posedge clk) begin
        if (pat_we) pram[pat_addr[7:0]] <= bus_wdata;
        pat_rdata <= pat_rom_present ? (pat_addr[7:0] ^ 8'h5A) : pram[pat_addr[7:0]];
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 last_we = pat_we;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        #2 d = rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R10 rvalid", 16'(rvalid), 16'h0);
        check("R10 rdata", 16'(rdata), 16'h0);
        rd(16'h3F07, d);
        check("R10 palette cleared", 16'(d), 16'h00);
    endtask

    task automatic t_region();
        @(negedge clk);
        bus_addr = 16'h1FFF; #1 check("R2 pattern top", 16'(sel), 16'd0);
        bus_addr = 16'h2000; #1 check("R2 nametable base", 16'(sel), 16'd1);
        bus_addr = 16'h3EFF; #1 check("R2 window top", 16'(sel), 16'd1);
        bus_addr = 16'h3F00; #1 check("R2 palette base", 16'(sel), 16'd2);
    endtask

    task automatic t_mirror_set();
        logic [7:0] d;
        mirror_sel = 1'b1;
        wr(16'h2005, 8'hA1);
        wr(16'h2405, 8'hB2);
        rd(16'h2805, d); check("R3 table2->table0", 16'(d), 16'hA1);
        rd(16'h2C05, d); check("R3 table3->table1", 16'(d), 16'hB2);
        rd(16'h2005, d); check("R3 table0 kept", 16'(d), 16'hA1);
        @(negedge clk); bus_addr = 16'h2C05;
        #1 check("R3 nt_addr", 16'(nt_addr), 16'h405);
    endtask

    task automatic t_mirror_clr();
        logic [7:0] d;
        mirror_sel = 1'b0;
        wr(16'h2005, 8'h11);
        wr(16'h2805, 8'h22);
        rd(16'h2405, d); check("R4 table1->table0", 16'(d), 16'h11);
        rd(16'h2C05, d); check("R4 table3->table2", 16'(d), 16'h22);
        @(negedge clk); bus_addr = 16'h2C05;
        #1 check("R4 nt_addr", 16'(nt_addr), 16'h405);
        bus_addr = 16'h2405;
        #1 check("R4 nt_addr t1", 16'(nt_addr), 16'h005);
    endtask

    task automatic t_window();
        logic [7:0] d;
        mirror_sel = 1'b1;
        wr(16'h3123, 8'h77);
        rd(16'h2123, d); check("R5 window to base", 16'(d), 16'h77);
        rd(16'h3923, d); check("R5 window table2 alias", 16'(d), 16'h77);
        mirror_sel = 1'b0;
        wr(16'h2A40, 8'h6E);
        rd(16'h3E40, d); check("R5 window flag clear", 16'(d), 16'h6E);
    endtask

    task automatic t_palette();
        logic [7:0] d;
        mirror_sel = 1'b1;
        wr(16'h2F03, 8'h99);
        wr(16'h3F03, 8'h3C);
        wr(16'h3F1F, 8'h15);
        rd(16'h3F23, d); check("R6 mirror 0x3F23", 16'(d), 16'h3C);
        rd(16'h3FE3, d); check("R6 mirror 0x3FE3", 16'(d), 16'h3C);
        rd(16'h3FFF, d); check("R6 top entry", 16'(d), 16'h15);
        rd(16'h2F03, d); check("R11 nametable untouched", 16'(d), 16'h99);
        wr(16'h2F10, 8'h42);
        check("R11 no pat_we on nametable", 16'(last_we), 16'h0);
    endtask

    task automatic t_pattern();
        logic [7:0] d;
        pat_rom_present = 1'b1;
        wr(16'h0123, 8'hEE);
        check("R8 write blocked", 16'(last_we), 16'h0);
        rd(16'h0123, d); check("R8 rom data", 16'(d), 16'h79);
        pat_rom_present = 1'b0;
        wr(16'h1042, 8'hC7);
        check("R7 pat_we", 16'(last_we), 16'h1);
        @(negedge clk); bus_addr = 16'h1042;
        #1 check("R7 pat_addr", 16'(pat_addr), 16'h1042);
        rd(16'h1042, d); check("R7 ram readback", 16'(d), 16'hC7);
        pat_rom_present = 1'b1;
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        mirror_sel = 1'b1;
        wr(16'hE00A, 8'h5B);
        rd(16'h200A, d); check("R1 wrapped write", 16'(d), 16'h5B);
        rd(16'h600A, d); check("R1 wrapped read", 16'(d), 16'h5B);
        @(negedge clk); bus_addr = 16'hFF05;
        #1 check("R1 wrapped palette sel", 16'(sel), 16'd2);
    endtask

    task automatic t_latency();
        logic [7:0] d;
        wr(16'h3F09, 8'hD4);
        @(negedge clk);
        bus_addr = 16'h3F09; bus_rd = 1'b1;
        #1 check("R9 not early", 16'(rvalid), 16'h0);
        @(posedge clk);
        #2 check("R9 rvalid", 16'(rvalid), 16'h1);
        check("R9 rdata", 16'(rdata), 16'hD4);
        @(negedge clk); bus_rd = 1'b0;
        @(posedge clk);
        #2 check("R9 rvalid drops", 16'(rvalid), 16'h0);
        check("R9 rdata idle", 16'(rdata), 16'h0);
        d = 8'h0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_region();
        t_mirror_set();
        t_mirror_clr();
        t_window();
        t_palette();
        t_pattern();
        t_wrap();
        t_latency();
        repeat (2) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule